// File: doc/BRIEF.md
# SPI Register Configuration Sequencer

This block is an SPI master that brings an audio converter's clock tree and serial-port master mode into a known state after reset. A fixed internal table of (register address, data) pairs is played out in order as 16-bit SPI write frames. The order is part of the contract with the converter. First the register page is selected and automatic clock configuration is switched off. Next come the PLL and internal clock dividers, then the word-clock and bit-clock outputs with their dividers. Last, a standby request is followed by a standby release.

An optional verify mode follows every write with a read of the same register and compares the returned byte with the value written. A mismatch raises a sticky error and records the table index of the first failure. When the sequencer is idle, a single-register read port can fetch any register for status checks. The SPI clock rate comes from a programmable half-period divider, so the block can run from a fast system clock down to SPI rates of a few tens of kHz.

The control path is one state machine. It has the states IDLE, WR_GO, WR_WAIT, CK_GO, CK_WAIT, STEP, RD_GO and RD_WAIT, and it moves between them as follows:

- IDLE to WR_GO on start.
- IDLE to RD_GO on a read request when start is low.
- Each GO state moves to its WAIT state after one cycle.
- WR_WAIT moves to CK_GO when a frame finishes in verify mode, or to STEP otherwise.
- CK_WAIT moves to STEP when a frame finishes.
- STEP moves to IDLE on the last entry, or to WR_GO otherwise.
- RD_WAIT moves to IDLE when a frame finishes.

The frame engine has its own states: IDLE, LO (SCLK low), HI (SCLK high), TAIL (last half period with chip select still low) and GAP (chip select high, recovery time).

Top module: `cfg_spi_seq`

## Requirements
- R1: Each frame has 16 bits and is sent MSB first. Bits [15:9] hold the 7-bit register address. Bit 8 is the direction flag, 1 for read and 0 for write. Bits [7:0] hold the write data, or zero for a read. SCLK idles low, and MOSI changes only after a falling SCLK edge, so it is stable at every rising edge. A read of register 63 is the frame 0x7F00, and a read of register 12 is 0x1900.
- R2: Chip select (active low) stays low for exactly 16 rising SCLK edges per frame. It rises only one half period after the 16th falling edge. It then stays high for at least 4 half periods (two SPI clock periods) before the next frame. SCLK is low whenever chip select is high.
- R3: During a read frame, the register value is taken from MISO at rising edges 9 to 16, MSB first, and returned on rd_data.
- R4: Each SCLK half period lasts clk_div+1 system clock cycles, where clk_div is 16 bits wide and is taken at the start of each frame.
- R5: A sequence writes this fixed order of (address, data) pairs, all in hex:
  - page select (00,00)
  - automatic clock configuration off (25,72)
  - PLL dividers P, J, D1, D2, R: (14,03) (15,0C) (16,00) (17,00) (18,00)
  - DSP, DAC, charge-pump and oscillator dividers: (1B,01) (1C,0F) (1D,03) (1E,00)
  - sample rate and instruction count: (22,00) (23,04) (24,00)
  - clock outputs enabled (09,11)
  - bit-clock divider (20,03), then word-clock divider (21,3F)
  - divider reset release (0C,7F)
  - standby request (02,10), then standby release (02,00)
  
  The table indices run 0 to 19 in this order.
- R6: start while idle raises busy on the next cycle. start while busy is ignored and adds no frames.
- R7: After the last table entry, done is high for exactly one cycle. busy is low in that same cycle.
- R8: With verify_en high at start, each write frame is followed by a read frame of the same address, which gives 40 frames in total.
- R9: In verify mode, a read-back byte that differs from the byte written sets err. err_idx then holds the table index of the first mismatch. Both hold until the next accepted start, which clears err.
- R10: rd_req while idle (and start low) issues one read frame of rd_addr. rd_valid then pulses for one cycle with the byte, and busy is low in that cycle. rd_req while busy is ignored.
- R11: During and just after reset, chip select is high, SCLK is low, and busy, done, err and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start the configuration sequence |
| verify_en | input | 1 | Read back and compare each write; taken at start |
| clk_div | input | 16 | SCLK half period minus one, in system clocks |
| rd_req | input | 1 | Request a single-register read |
| rd_addr | input | 7 | Register address for the single read |
| busy | output | 1 | A sequence or a single read is in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |
| err | output | 1 | Sticky verify mismatch flag |
| err_idx | output | 5 | Table index of the first mismatch |
| rd_valid | output | 1 | One-cycle pulse when rd_data is valid |
| rd_data | output | 8 | Byte from the single read |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |

## Verification
The assertions rely on the reset being asserted before the first clock, and on spi_miso being driven by a slave that changes it only on falling SCLK edges. They do not assume that start or rd_req are withheld while busy, so the stimulus deliberately pulses both in the middle of a sequence. The bench slave model updates MISO on falling SCLK edges and shows a pulled-up level while chip select is high. Random dividers are kept small, except for one directed slow read with a half period of 2000 cycles. A chosen register in the slave ignores writes, which forces a known verify mismatch.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + 1 + DATA_W;
    localparam int N_STEPS = 20;
    localparam int IDX_W   = $clog2(N_STEPS);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_set_t;

    // Ordered bring-up list: page, clock tree, port master mode, standby pair.
    function automatic reg_set_t step_entry(input logic [IDX_W-1:0] i);
        reg_set_t e;
        unique case (i)
            5'd0:    e = {7'h00, 8'h00};
            5'd1:    e = {7'h25, 8'h72};
            5'd2:    e = {7'h14, 8'h03};
            5'd3:    e = {7'h15, 8'h0C};
            5'd4:    e = {7'h16, 8'h00};
            5'd5:    e = {7'h17, 8'h00};
            5'd6:    e = {7'h18, 8'h00};
            5'd7:    e = {7'h1B, 8'h01};
            5'd8:    e = {7'h1C, 8'h0F};
            5'd9:    e = {7'h1D, 8'h03};
            5'd10:   e = {7'h1E, 8'h00};
            5'd11:   e = {7'h22, 8'h00};
            5'd12:   e = {7'h23, 8'h04};
            5'd13:   e = {7'h24, 8'h00};
            5'd14:   e = {7'h09, 8'h11};
            5'd15:   e = {7'h20, 8'h03};
            5'd16:   e = {7'h21, 8'h3F};
            5'd17:   e = {7'h0C, 8'h7F};
            5'd18:   e = {7'h02, 8'h10};
            5'd19:   e = {7'h02, 8'h00};
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/cfg_seq_rom.sv
module cfg_seq_rom
    import cfg_seq_pkg::*;
#(
    parameter int N = N_STEPS
) (
    input  logic [IDX_W-1:0] idx,
    output reg_set_t         ent,
    output logic             last
);

    always_comb begin
        ent  = step_entry(idx);
        last = (idx == IDX_W'(N - 1));
    end

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_frame_eng.sv
module spi_frame_eng #(
    parameter int DIV_W      = 16,
    parameter int FRAME_W    = 16,
    parameter int GAP_HALVES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    input  logic [DIV_W-1:0]   div,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic               fin,
    output logic [FRAME_W-1:0] rx
);

    localparam int BIT_W = $clog2(FRAME_W + 1);
    localparam int GAP_W = $clog2(GAP_HALVES + 1);

    typedef enum logic [2:0] {E_IDLE, E_LO, E_HI, E_TAIL, E_GAP} eng_st_t;

    eng_st_t            st, nxt;
    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] tx;
    logic [BIT_W-1:0]   bitn;
    logic [GAP_W-1:0]   gapn;
    logic               tick;
    logic               last_bit;
    logic               gap_end;

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st != E_IDLE),
        .div  (div_q),
        .tick (tick)
    );

    assign last_bit = (bitn == BIT_W'(FRAME_W));
    assign gap_end  = (gapn == GAP_W'(GAP_HALVES - 1));
    assign mosi     = tx[FRAME_W-1];
    assign fin      = (st == E_GAP) && tick && gap_end;

    always_comb begin
        nxt = st;
        unique case (st)
            E_IDLE: if (go)   nxt = E_LO;
            E_LO:   if (tick) nxt = E_HI;
            E_HI:   if (tick) nxt = last_bit ? E_TAIL : E_LO;
            E_TAIL: if (tick) nxt = E_GAP;
            E_GAP:  if (tick && gap_end) nxt = E_IDLE;
            default: nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tx    <= '0;
            rx    <= '0;
            bitn  <= '0;
            gapn  <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
        end else begin
            unique case (st)
                E_IDLE: if (go) begin
                    div_q <= div;
                    tx    <= frame;
                    bitn  <= '0;
                    sclk  <= 1'b0;
                    cs_n  <= 1'b0;
                end
                E_LO: if (tick) begin
                    sclk <= 1'b1;
                    rx   <= {rx[FRAME_W-2:0], miso};
                    bitn <= bitn + 1'b1;
                end
                E_HI: if (tick) begin
                    sclk <= 1'b0;
                    if (!last_bit) tx <= {tx[FRAME_W-2:0], 1'b0};
                end
                E_TAIL: if (tick) begin
                    cs_n <= 1'b1;
                    gapn <= '0;
                end
                E_GAP: if (tick) gapn <= gapn + 1'b1;
                default: ;
            endcase
        end
    end

    // R2: clock is parked low whenever the slave is deselected
    p_sclk_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R1: data out never moves across a rising clock edge
    p_mosi_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(sclk)) |-> $stable(mosi));

    // R2: select still low for the tail half period after the last falling edge
    p_cs_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_HI && tick && last_bit) |=> !cs_n);

    // R2: a new frame never starts inside the recovery gap
    p_no_early_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_GAP) |=> (cs_n || $past(fin)));

endmodule

// File: rtl/cfg_spi_seq.sv
module cfg_spi_seq
    import cfg_seq_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int GAP_HALVES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  err_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    typedef enum logic [2:0] {
        T_IDLE, T_WR_GO, T_WR_WAIT, T_CK_GO, T_CK_WAIT, T_STEP, T_RD_GO, T_RD_WAIT
    } seq_st_t;

    seq_st_t            st, nxt;
    logic [IDX_W-1:0]   idx;
    logic               verify_q;
    logic [ADDR_W-1:0]  rd_addr_q;
    reg_set_t           ent;
    logic               last;
    logic               go;
    logic               fin;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] rx;

    cfg_seq_rom #(.N(N_STEPS)) u_rom (
        .idx (idx),
        .ent (ent),
        .last(last)
    );

    spi_frame_eng #(
        .DIV_W     (DIV_W),
        .FRAME_W   (FRAME_W),
        .GAP_HALVES(GAP_HALVES)
    ) u_eng (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .frame(frame),
        .div  (clk_div),
        .miso (spi_miso),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .fin  (fin),
        .rx   (rx)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            T_IDLE:    if (start) nxt = T_WR_GO;
                       else if (rd_req) nxt = T_RD_GO;
            T_WR_GO:   nxt = T_WR_WAIT;
            T_WR_WAIT: if (fin) nxt = verify_q ? T_CK_GO : T_STEP;
            T_CK_GO:   nxt = T_CK_WAIT;
            T_CK_WAIT: if (fin) nxt = T_STEP;
            T_STEP:    nxt = last ? T_IDLE : T_WR_GO;
            T_RD_GO:   nxt = T_RD_WAIT;
            T_RD_WAIT: if (fin) nxt = T_IDLE;
            default:   nxt = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= nxt;
    end

    assign busy = (st != T_IDLE);
    assign go   = (st == T_WR_GO) || (st == T_CK_GO) || (st == T_RD_GO);

    always_comb begin
        unique case (st)
            T_WR_GO: frame = {ent.addr, 1'b0, ent.data};
            T_CK_GO: frame = {ent.addr, 1'b1, {DATA_W{1'b0}}};
            T_RD_GO: frame = {rd_addr_q, 1'b1, {DATA_W{1'b0}}};
            default: frame = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            verify_q  <= 1'b0;
            rd_addr_q <= '0;
            err       <= 1'b0;
            err_idx   <= '0;
            done      <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            unique case (st)
                T_IDLE: begin
                    if (start) begin
                        idx      <= '0;
                        verify_q <= verify_en;
                        err      <= 1'b0;
                    end else if (rd_req) begin
                        rd_addr_q <= rd_addr;
                    end
                end
                T_CK_WAIT: if (fin && !err && (rx[DATA_W-1:0] != ent.data)) begin
                    err     <= 1'b1;
                    err_idx <= idx;
                end
                T_STEP: begin
                    if (last) done <= 1'b1;
                    else      idx  <= idx + 1'b1;
                end
                T_RD_WAIT: if (fin) begin
                    rd_valid <= 1'b1;
                    rd_data  <= rx[DATA_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R6: an accepted start makes the block busy on the next cycle
    p_busy_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: error flag and index hold until a new accepted start
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(start && !busy)) |=> (err && $stable(err_idx)));

    // R10: read result appears only once idle
    p_rdv_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

endmodule

// File: tb/sim_cfg_spi_seq.sv
module sim_cfg_spi_seq;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        verify_en = 1'b0;
    logic [15:0] clk_div = 16'd1;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        busy, done, err, rd_valid;
    logic [4:0]  err_idx;
    logic [7:0]  rd_data;
    logic        sclk, cs_n, mosi, miso;

    always #(CLK_NS/2) clk = ~clk;

    cfg_spi_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en),
        .clk_div(clk_div), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
        .done(done), .err(err), .err_idx(err_idx), .rd_valid(rd_valid),
        .rd_data(rd_data), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bring-up list, written from the requirement text.
    function automatic logic [14:0] exp_step(input int i);
        logic [14:0] t [20];
        t = '{ {7'h00,8'h00}, {7'h25,8'h72}, {7'h14,8'h03}, {7'h15,8'h0C},
               {7'h16,8'h00}, {7'h17,8'h00}, {7'h18,8'h00}, {7'h1B,8'h01},
               {7'h1C,8'h0F}, {7'h1D,8'h03}, {7'h1E,8'h00}, {7'h22,8'h00},
               {7'h23,8'h04}, {7'h24,8'h00}, {7'h09,8'h11}, {7'h20,8'h03},
               {7'h21,8'h3F}, {7'h0C,8'h7F}, {7'h02,8'h10}, {7'h02,8'h00} };
        return t[i];
    endfunction

    function automatic logic [15:0] exp_frame(input bit ver, input int k);
        logic [14:0] e;
        e = exp_step(ver ? k / 2 : k);
        if (ver && (k % 2 == 1)) return {e[14:8], 1'b1, 8'h00};
        return {e[14:8], 1'b0, e[7:0]};
    endfunction

    // ---------------- slave model ----------------
    logic [7:0]  regs [128];
    logic [15:0] frames [64];
    int          nfr = 0;
    logic [15:0] s_sh = '0;
    int          s_bits = 0;
    logic [6:0]  s_addr = '0;
    logic        s_rd = 1'b0;
    logic        miso_r = 1'b0;
    bit          stuck_en = 1'b0;
    logic [6:0]  stuck_addr = '0;

    assign miso = cs_n ? 1'b1 : miso_r;

    always @(negedge cs_n) begin
        s_bits = 0;
        miso_r = 1'b0;
    end

    always @(posedge cs_n) begin
        if (rst_n) chk(s_bits == 16, "R2 edges per frame", s_bits, 16);
    end

    always @(posedge sclk) begin
        s_sh = {s_sh[14:0], mosi};
        s_bits++;
        if (s_bits == 8) begin
            s_addr = s_sh[7:1];
            s_rd   = s_sh[0];
        end
        if (s_bits == 16) begin
            if (nfr < 64) frames[nfr] = s_sh;
            nfr++;
            if (!s_sh[8] && !(stuck_en && s_sh[15:9] == stuck_addr))
                regs[s_sh[15:9]] = s_sh[7:0];
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && s_bits >= 8 && s_bits < 16)
            miso_r = s_rd ? regs[s_addr][15 - s_bits] : 1'b0;
    end

    // ---------------- timing monitor ----------------
    int cur_div = 1;
    int hi_cnt = 0, hp_bad = 0;
    int gap = 0, gap_bad = 0;
    bit seen_low = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk) hi_cnt++;
            else if (hi_cnt != 0) begin
                if (hi_cnt != cur_div + 1) hp_bad++;
                hi_cnt = 0;
            end
            if (cs_n) gap++;
            else begin
                if (gap > 0) begin
                    if (seen_low && gap < 4 * (cur_div + 1)) gap_bad++;
                    gap = 0;
                end
                seen_low = 1'b1;
            end
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chk(1'b0, "watchdog", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic prep(input int dv);
        nfr = 0;
        cur_div = dv;
        hp_bad = 0;
        gap_bad = 0;
        gap = 0;
        seen_low = 1'b0;
        clk_div = 16'(dv);
    endtask

    task automatic run_seq(input bit ver, input int dv);
        int nexp;
        prep(dv);
        @(negedge clk);
        verify_en = ver;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R6 busy after start", busy, 1);
        for (int n = 0; n < 150000; n++) begin
            @(negedge clk);
            if (n == 300) begin start = 1'b1; rd_req = 1'b1; rd_addr = 7'h3F; end
            if (n == 301) begin start = 1'b0; rd_req = 1'b0; end
            if (done) break;
        end
        chk(done === 1'b1, "R7 done seen", done, 1);
        chk(busy === 1'b0, "R7 idle with done", busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R7 done one cycle", done, 0);
        nexp = ver ? 40 : 20;
        chk(nfr == nexp, ver ? "R8 frame count" : "R6 R10 frame count", nfr, nexp);
        for (int k = 0; k < nexp && k < nfr; k++)
            chk(frames[k] == exp_frame(ver, k), ver ? "R8 frame" : "R5 frame",
                frames[k], exp_frame(ver, k));
        chk(hp_bad == 0, "R4 half period", hp_bad, 0);
        chk(gap_bad == 0, "R2 cs gap", gap_bad, 0);
    endtask

    task automatic do_read(input logic [6:0] a, input int dv);
        int n;
        prep(dv);
        @(negedge clk);
        rd_addr = a;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        n = 0;
        while (!rd_valid && n < 100000) begin
            @(negedge clk);
            n++;
        end
        chk(rd_valid === 1'b1, "R10 rd_valid", rd_valid, 1);
        chk(busy === 1'b0, "R10 idle with rd_valid", busy, 0);
        chk(rd_data == regs[a], "R3 read byte", rd_data, regs[a]);
        chk(nfr == 1, "R10 one frame", nfr, 1);
        chk(frames[0] == {a, 1'b1, 8'h00}, "R1 read frame", frames[0], {a, 1'b1, 8'h00});
        chk(hp_bad == 0, "R4 half period", hp_bad, 0);
        @(negedge clk);
        chk(rd_valid === 1'b0, "R10 pulse", rd_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) regs[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0, "R11 spi idle", {cs_n, sclk}, 2);
        chk(busy === 1'b0 && done === 1'b0, "R11 busy done", {busy, done}, 0);
        chk(err === 1'b0 && rd_valid === 1'b0, "R11 err rd_valid", {err, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_seq(1'b0, 1);
        run_seq(1'b0, int'($urandom_range(0, 3)));
        run_seq(1'b1, int'($urandom_range(0, 3)));
        chk(err === 1'b0, "R8 no mismatch", err, 0);

        // R9: a register that ignores writes forces a mismatch at index 8
        stuck_en = 1'b1;
        stuck_addr = 7'h1C;
        regs[7'h1C] = 8'hA5;
        run_seq(1'b1, 2);
        chk(err === 1'b1, "R9 err set", err, 1);
        chk(err_idx == 5'd8, "R9 err_idx", err_idx, 8);
        stuck_en = 1'b0;
        run_seq(1'b1, 0);
        chk(err === 1'b0, "R9 err cleared", err, 0);

        // directed reads of status registers, then random ones
        regs[63] = 8'h20;
        do_read(7'd63, 1);
        chk(frames[0] == 16'h7F00, "R1 frame reg63", frames[0], 16'h7F00);
        do_read(7'd12, 0);
        chk(frames[0] == 16'h1900, "R1 frame reg12", frames[0], 16'h1900);
        for (int r = 0; r < 8; r++)
            do_read(7'($urandom), int'($urandom_range(0, 3)));

        // R4: slow SPI rate
        do_read(7'h21, 1999);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule